// File: doc/BRIEF.md
# Double-Buffered Compare PWM Generator

This block makes a pulse-width modulated waveform on one output from a 16-bit compare timer. Software writes an on-time value and a period value into buffer registers. The compare logic works from internal active copies of those two values. The active copies are reloaded from the buffers only at a period boundary, so a change that software makes part-way through a period never produces a partial or corrupted pulse. The waveform can be edge-aligned, where it starts at the boundary, or center-aligned, where it sits between two compare points.

A 3-bit field selects the timer's count enable. It can be one of seven external enable strobes or every system clock. A 5-bit field selects what restarts the timer. It can be one of 31 external sync lines or the block's own period match. A mode bit changes the timer from free-running sync operation to one-shot triggered operation. A fault input, when enabled, overrides the output with a programmed level, and can also release the output driver. The fault condition is latched until software acknowledges it. An invert bit flips the final output polarity. A sticky interrupt flag records compare and period match events.

Top module: `dbc_pwm`

## Requirements
- R1: After reset, `pwm_out` is 0, `pwm_oe` is 1, `irq` is 0, and all four registers read 0. Register addresses are: 0 on-time buffer, 1 period buffer, 2 configuration, 3 status.
- R2: A read of address 0 or 1 returns the last value written there, even when the compare logic is still using an older active value.
- R3: The active on-time and period copies take the buffer values only on a timer rollover. They also follow the buffers while the mode field selects "off", and while triggered operation is waiting for a trigger.
- R4: When the sync select field cfg[10:6] is 31, the timer counts 0 up to the active period P. On the enabled tick at P it returns to 0, which gives a period of P+1 ticks.
- R5: Mode field cfg[2:0] = 6 selects edge-aligned output. The output is high while timer < on-time, constantly low for on-time 0, and constantly high for on-time ≥ period. Any mode value other than 6 or 7 holds the timer at 0 and drives a low raw level.
- R6: Mode field cfg[2:0] = 7 selects center-aligned output. The output is high while on-time ≤ timer < period.
- R7: Clock select cfg[5:3] values 0 to 6 make the timer advance only in cycles where `clk_en_src[value]` is 1. Value 7 advances it every cycle.
- R8: With cfg[11] = 0 and sync select s < 31, the timer free-runs and wraps at 16 bits. It returns to 0, with a shadow reload, on any cycle where `sync_src[s]` is 1.
- R9: With cfg[11] = 1, the timer is held at 0 with a low raw output until `sync_src[s]` is 1. It then counts until its period match, which reloads the shadows and stops it again. Sync select 31 never triggers.
- R10: With fault enable cfg[13] = 1, a high `flt_in` immediately forces the pre-inversion level to cfg[14]. If cfg[15] = 1, `pwm_oe` also goes to 0 while forced.
- R11: The fault is latched in status bit 0. Writing status with bit 0 set clears it only while the fault input is inactive. The forced output then persists until the next rollover, or until the mode is off.
- R12: Invert bit cfg[12] flips `pwm_out` after the fault override.
- R13: The interrupt flag, visible on `irq` and status bit 1, is set on any counted tick where the timer equals the active on-time or the active period. It is cleared by writing status with bit 1 set, and a set event in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| clk_en_src | input | 7 | Selectable timer count-enable strobes |
| sync_src | input | 31 | Selectable external sync/trigger lines |
| flt_in | input | 1 | Fault input, active high |
| pwm_out | output | 1 | PWM output level |
| pwm_oe | output | 1 | Output driver enable (0 = tristate) |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench writes a new on-time in the middle of a period. A design that loaded it at once would shorten or stretch the running pulse, and the bench would see the wrong level within that period. The bench also covers on-time 0 and on-time above the period. An off-by-one compare there would leak a single-tick glitch. It runs gated clock enables, external sync pulses and one-shot triggering. A wrong source index, or a timer that kept running after its triggered period, would drift from the reference. The fault sequence tries to clear the latch while the fault is still active, then clears it properly. A design that dropped the latch too early, or released the override before the next boundary, would show the wrong output and driver enable.

// File: rtl/dbc_pwm_pkg.sv
package dbc_pwm_pkg;

  localparam logic [1:0] ADDR_DUTY = 2'd0;
  localparam logic [1:0] ADDR_PRD  = 2'd1;
  localparam logic [1:0] ADDR_CFG  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam logic [2:0] MODE_EDGE = 3'b110;
  localparam logic [2:0] MODE_CTR  = 3'b111;
  localparam logic [4:0] SYNC_SELF = 5'h1F;

  localparam int N_EN   = 7;
  localparam int N_SYNC = 31;

  typedef struct packed {
    logic       flt_tri;   // [15]
    logic       flt_lvl;   // [14]
    logic       flt_en;    // [13]
    logic       inv;       // [12]
    logic       trig;      // [11]
    logic [4:0] ssel;      // [10:6]
    logic [2:0] csel;      // [5:3]
    logic [2:0] mode;      // [2:0]
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic logic edge_lvl(input logic [31:0] t, input logic [31:0] d,
                                    input logic [31:0] p);
    return (t < d) || (d >= p);
  endfunction

  function automatic logic ctr_lvl(input logic [31:0] t, input logic [31:0] d,
                                   input logic [31:0] p);
    return (t >= d) && (t < p);
  endfunction

endpackage

// File: rtl/dbc_pwm_timebase.sv
module dbc_pwm_timebase
  import dbc_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              trig,
  input  logic [2:0]        csel,
  input  logic [4:0]        ssel,
  input  logic [N_EN-1:0]   en_src,
  input  logic [N_SYNC-1:0] sync_src,
  input  logic [W-1:0]      duty_buf,
  input  logic [W-1:0]      prd_buf,
  output logic [W-1:0]      tmr,
  output logic [W-1:0]      duty_act,
  output logic [W-1:0]      prd_act,
  output logic              counting,
  output logic              prd_hit,
  output logic              cmp_hit,
  output logic              roll,
  output logic              ld
);

  logic [N_EN:0]   en_vec;
  logic [N_SYNC:0] sync_vec;
  logic            tick;
  logic            ext_evt;
  logic            run;

  assign en_vec   = {1'b1, en_src};
  assign sync_vec = {1'b0, sync_src};

  always_comb begin
    tick     = en_vec[csel];
    ext_evt  = (ssel == SYNC_SELF) ? 1'b0 : sync_vec[ssel];
    counting = active && (!trig || run);
    prd_hit  = counting && tick && (tmr == prd_act);
    cmp_hit  = counting && tick && (tmr == duty_act);
    if (trig) roll = prd_hit;
    else      roll = active && ((ssel == SYNC_SELF) ? prd_hit : ext_evt);
    ld = !active || roll || (trig && !run);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      run      <= 1'b0;
      duty_act <= '0;
      prd_act  <= '0;
    end else begin
      if (!active || !trig)    run <= 1'b0;
      else if (!run && ext_evt) run <= 1'b1;
      else if (prd_hit)        run <= 1'b0;

      if (!counting || roll) tmr <= '0;
      else if (tick)         tmr <= tmr + 1'b1;

      if (ld) begin
        duty_act <= duty_buf;
        prd_act  <= prd_buf;
      end
    end
  end

endmodule

// File: rtl/dbc_pwm_regs.sv
module dbc_pwm_regs
  import dbc_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         fault_set,
  input  logic         irq_set,
  output logic [W-1:0] duty_buf,
  output logic [W-1:0] prd_buf,
  output cfg_t         cfg,
  output logic         flt_lat,
  output logic         irq_flag
);

  logic stat_wr;
  assign stat_wr = wr_en && (wr_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_buf <= '0;
      prd_buf  <= '0;
      cfg      <= '0;
      flt_lat  <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_DUTY) duty_buf <= wr_data;
      if (wr_en && wr_addr == ADDR_PRD)  prd_buf  <= wr_data;
      if (wr_en && wr_addr == ADDR_CFG)  cfg      <= cfg_t'(wr_data[CFG_W-1:0]);

      if (fault_set)                 flt_lat <= 1'b1;
      else if (stat_wr && wr_data[0]) flt_lat <= 1'b0;

      if (irq_set)                   irq_flag <= 1'b1;
      else if (stat_wr && wr_data[1]) irq_flag <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_DUTY: rd_data = duty_buf;
      ADDR_PRD:  rd_data = prd_buf;
      ADDR_CFG:  rd_data = W'(cfg);
      default:   rd_data = W'({irq_flag, flt_lat});
    endcase
  end

endmodule

// File: rtl/dbc_pwm_outstage.sv
module dbc_pwm_outstage
  import dbc_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode,
  input  logic         active,
  input  logic         counting,
  input  logic         roll,
  input  logic [W-1:0] tmr,
  input  logic [W-1:0] duty_act,
  input  logic [W-1:0] prd_act,
  input  logic         flt_en,
  input  logic         flt_lvl,
  input  logic         flt_tri,
  input  logic         inv,
  input  logic         flt_in,
  input  logic         flt_lat,
  output logic         fault_set,
  output logic         fault_force,
  output logic         pwm_out,
  output logic         pwm_oe
);

  logic flt_hold;
  logic raw;
  logic lvl;

  always_comb begin
    fault_set   = flt_en && flt_in;
    fault_force = fault_set || flt_hold;
    case (mode)
      MODE_EDGE: raw = counting && edge_lvl(32'(tmr), 32'(duty_act), 32'(prd_act));
      MODE_CTR:  raw = counting && ctr_lvl(32'(tmr), 32'(duty_act), 32'(prd_act));
      default:   raw = 1'b0;
    endcase
    lvl     = fault_force ? flt_lvl : raw;
    pwm_out = lvl ^ inv;
    pwm_oe  = !(fault_force && flt_tri);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               flt_hold <= 1'b0;
    else if (fault_set)                       flt_hold <= 1'b1;
    else if (!flt_lat && (roll || !active))   flt_hold <= 1'b0;
  end

endmodule

// File: rtl/dbc_pwm.sv
module dbc_pwm
  import dbc_pwm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [1:0]        rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic [N_EN-1:0]   clk_en_src,
  input  logic [N_SYNC-1:0] sync_src,
  input  logic              flt_in,
  output logic              pwm_out,
  output logic              pwm_oe,
  output logic              irq
);

  cfg_t         cfg;
  logic [W-1:0] duty_buf, prd_buf, tmr, duty_act, prd_act;
  logic         active, counting, prd_hit, cmp_hit, roll, ld;
  logic         fault_set, fault_force, flt_lat, irq_flag;
  logic         flt_lvl, flt_tri, inv;

  assign active  = (cfg.mode == MODE_EDGE) || (cfg.mode == MODE_CTR);
  assign flt_lvl = cfg.flt_lvl;
  assign flt_tri = cfg.flt_tri;
  assign inv     = cfg.inv;
  assign irq     = irq_flag;

  dbc_pwm_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fault_set(fault_set),
    .irq_set(cmp_hit || prd_hit), .duty_buf(duty_buf), .prd_buf(prd_buf),
    .cfg(cfg), .flt_lat(flt_lat), .irq_flag(irq_flag)
  );

  dbc_pwm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .active(active), .trig(cfg.trig), .csel(cfg.csel),
    .ssel(cfg.ssel), .en_src(clk_en_src), .sync_src(sync_src), .duty_buf(duty_buf),
    .prd_buf(prd_buf), .tmr(tmr), .duty_act(duty_act), .prd_act(prd_act),
    .counting(counting), .prd_hit(prd_hit), .cmp_hit(cmp_hit), .roll(roll), .ld(ld)
  );

  dbc_pwm_outstage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(cfg.mode), .active(active), .counting(counting),
    .roll(roll), .tmr(tmr), .duty_act(duty_act), .prd_act(prd_act),
    .flt_en(cfg.flt_en), .flt_lvl(flt_lvl), .flt_tri(flt_tri), .inv(inv),
    .flt_in(flt_in), .flt_lat(flt_lat), .fault_set(fault_set),
    .fault_force(fault_force), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
  );

endmodule

// File: rtl/dbc_pwm_chk.sv
module dbc_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld,
  input logic         roll,
  input logic [W-1:0] tmr,
  input logic [W-1:0] duty_act,
  input logic [W-1:0] prd_act,
  input logic         cmp_hit,
  input logic         prd_hit,
  input logic         irq,
  input logic         active,
  input logic         fault_set,
  input logic         fault_force,
  input logic         flt_lat,
  input logic         flt_lvl,
  input logic         flt_tri,
  input logic         inv,
  input logic         pwm_out,
  input logic         pwm_oe,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] wr_data
);

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(duty_act) && $stable(prd_act))); // R3
  AST_ROLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> (tmr == '0)); // R4
  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fault_force |-> (pwm_out == (flt_lvl ^ inv))); // R12
  AST_FAULT_TRI: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_force && flt_tri) |-> !pwm_oe); // R10
  AST_OE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_force |-> pwm_oe); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit || prd_hit) |=> irq); // R13
  AST_LATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fault_set |=> flt_lat); // R11
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_lat && !(wr_en && wr_addr == 2'd3 && wr_data[0])) |=> flt_lat); // R11
  AST_OFF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !fault_force) |-> (pwm_out == inv)); // R5

endmodule

bind dbc_pwm dbc_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld(ld), .roll(roll), .tmr(tmr), .duty_act(duty_act),
  .prd_act(prd_act), .cmp_hit(cmp_hit), .prd_hit(prd_hit), .irq(irq), .active(active),
  .fault_set(fault_set), .fault_force(fault_force), .flt_lat(flt_lat),
  .flt_lvl(flt_lvl), .flt_tri(flt_tri), .inv(inv), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/dbc_pwm_tb.sv
module dbc_pwm_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rd_data;
  logic [6:0]  clk_en_src = 7'd0;
  logic [30:0] sync_src = 31'd0;
  logic        flt_in = 1'b0;
  logic        pwm_out, pwm_oe, irq;

  int checks = 0;
  int fails = 0;
  bit mon = 0;
  bit done = 0;
  string ph = "R1";

  // reference state
  int m_tmr, m_run, m_dact, m_pact, m_rduty, m_rprd, m_cfg, m_flat, m_fhold, m_irq;

  always #2 clk = ~clk;

  dbc_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .clk_en_src(clk_en_src), .sync_src(sync_src),
    .flt_in(flt_in), .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", r, $time, act, exp);
    end
  endtask

  function automatic int fld(input int v, input int lsb, input int n);
    return (v >> lsb) & ((1 << n) - 1);
  endfunction

  function automatic bit m_on();
    return fld(m_cfg, 0, 3) >= 6;
  endfunction

  function automatic bit m_counting();
    return m_on() && (fld(m_cfg, 11, 1) == 0 || m_run != 0);
  endfunction

  // expected {pwm_out, pwm_oe, irq}
  function automatic int m_pins();
    bit forced, lvl, raw;
    int md;
    md = fld(m_cfg, 0, 3);
    forced = (fld(m_cfg, 13, 1) == 1 && flt_in) || m_fhold != 0;
    raw = 0;
    if (m_counting()) begin
      if (md == 6) raw = (m_tmr < m_dact) || (m_dact >= m_pact);
      if (md == 7) raw = (m_tmr >= m_dact) && (m_tmr < m_pact);
    end
    lvl = forced ? bit'(fld(m_cfg, 14, 1)) : raw;
    lvl = lvl ^ bit'(fld(m_cfg, 12, 1));
    return (int'(lvl) << 2) | ((forced && fld(m_cfg, 15, 1) == 1) ? 0 : 2) | (m_irq != 0 ? 1 : 0);
  endfunction

  function automatic int m_read();
    case (int'(rd_addr))
      0: return m_rduty;
      1: return m_rprd;
      2: return m_cfg;
      default: return (m_irq << 1) | m_flat;
    endcase
  endfunction

  always @(posedge clk) begin
    bit on, cnt, tk, phit, chit, ext, rl, fs, ld, trg, sw;
    int cs, ss, nt;
    if (!rst_n) begin
      m_tmr = 0; m_run = 0; m_dact = 0; m_pact = 0; m_rduty = 0; m_rprd = 0;
      m_cfg = 0; m_flat = 0; m_fhold = 0; m_irq = 0;
    end else begin
      on  = m_on();
      cnt = m_counting();
      trg = fld(m_cfg, 11, 1) == 1;
      cs  = fld(m_cfg, 3, 3);
      ss  = fld(m_cfg, 6, 5);
      tk  = (cs == 7) ? 1'b1 : clk_en_src[cs];
      phit = cnt && tk && m_tmr == m_pact;
      chit = cnt && tk && m_tmr == m_dact;
      ext  = (ss == 31) ? 1'b0 : sync_src[ss];
      if (trg) rl = phit;
      else     rl = on && ((ss == 31) ? phit : ext);
      fs = fld(m_cfg, 13, 1) == 1 && flt_in;
      ld = !on || rl || (trg && m_run == 0);
      sw = wr_en && wr_addr == 2'd3;
      nt = (!cnt || rl) ? 0 : (tk ? ((m_tmr + 1) % 65536) : m_tmr);
      if (fs) m_fhold = 1;
      else if (m_flat == 0 && (rl || !on)) m_fhold = 0;
      if (fs) m_flat = 1;
      else if (sw && wr_data[0]) m_flat = 0;
      if (chit || phit) m_irq = 1;
      else if (sw && wr_data[1]) m_irq = 0;
      if (!on || !trg) m_run = 0;
      else if (m_run == 0 && ext) m_run = 1;
      else if (phit) m_run = 0;
      if (ld) begin m_dact = m_rduty; m_pact = m_rprd; end
      m_tmr = nt;
      if (wr_en && wr_addr == 2'd0) m_rduty = int'(wr_data);
      if (wr_en && wr_addr == 2'd1) m_rprd  = int'(wr_data);
      if (wr_en && wr_addr == 2'd2) m_cfg   = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    #1;
    if (mon && !done) begin
      chk(ph, int'({pwm_out, pwm_oe, irq}), m_pins());
      chk(ph, int'(rd_data), m_read());
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 50000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    int hi, r1, r2;
    bit prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1", int'(pwm_out), 0);
    chk("R1", int'(pwm_oe), 1);
    chk("R1", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk("R1", int'(rd_data), 0);
    end
    mon = 1;

    ph = "R2";
    wr(0, 4); wr(1, 9);
    rd_addr = 2'd0; #1; chk("R2", int'(rd_data), 4);
    rd_addr = 2'd1; #1; chk("R2", int'(rd_data), 9);

    ph = "R5";
    wr(2, 16'h07FE);
    hi = 0; r1 = -1; r2 = -1; prev = pwm_out;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      if (pwm_out) hi++;
      if (pwm_out && !prev) begin if (r1 < 0) r1 = k; else if (r2 < 0) r2 = k; end
      prev = pwm_out;
    end
    chk("R5", hi, 8);
    chk("R4", r2 - r1, 10);

    ph = "R3";
    idle(3);
    wr(0, 7);
    rd_addr = 2'd0; #1; chk("R3", int'(rd_data), 7);
    idle(25);

    ph = "R5";
    wr(0, 0); idle(22);
    wr(0, 12); idle(22);

    ph = "R6";
    wr(0, 3); wr(1, 8); wr(2, 16'h07FF); idle(25);

    ph = "R7";
    wr(0, 2); wr(1, 5); wr(2, 2006);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      clk_en_src = (k % 3 == 0) ? 7'd4 : 7'd0;
    end
    clk_en_src = 7'd0;

    ph = "R8";
    wr(2, 382); wr(1, 200);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      sync_src = (k % 13 == 12) ? 31'h20 : 31'h0;
    end
    sync_src = 31'h0;

    ph = "R9";
    wr(1, 5); wr(2, 2430); idle(8);
    @(negedge clk); sync_src = 31'h20;
    @(negedge clk); sync_src = 31'h0;
    idle(15);
    @(negedge clk); sync_src = 31'h20;
    @(negedge clk); sync_src = 31'h0;
    idle(12);

    ph = "R13";
    rd_addr = 2'd3;
    wr(2, 16'h07FE); idle(6);
    wr(2, 0);
    wr(3, 2);
    #1; chk("R13", int'(irq), 0);

    ph = "R10";
    wr(1, 9); wr(0, 4); wr(2, 16'hE7FE); idle(4);
    @(negedge clk); flt_in = 1'b1;
    idle(3); #1;
    chk("R10", int'(pwm_oe), 0);
    chk("R10", int'(pwm_out), 1);

    ph = "R11";
    wr(3, 1); #1;
    chk("R11", int'(rd_data) & 1, 1);
    @(negedge clk); flt_in = 1'b0;
    idle(2); #1;
    chk("R11", int'(pwm_oe), 0);
    wr(3, 1); #1;
    chk("R11", int'(rd_data) & 1, 0);
    idle(15); #1;
    chk("R11", int'(pwm_oe), 1);

    ph = "R12";
    wr(2, 16'h37FE); idle(3);
    @(negedge clk); flt_in = 1'b1;
    @(negedge clk); #1;
    chk("R12", int'(pwm_out), 1);
    chk("R12", int'(pwm_oe), 1);
    flt_in = 1'b0;
    wr(3, 3); idle(15);

    finish_run();
  end

endmodule